// File: doc/BRIEF.md
# Slave Programming Strobe Sequencer

This block sits on the programmer side of a non-volatile memory that is written and read back through a slave programming port. It produces three active-low strobes on that port: an address latch strobe, a program pulse and an address advance strobe. It drives a shared 16-bit bus with the address first and then with write data. It samples a verify flag that the device returns after each word. Every interval is a fixed number of oscillator cycles, and each count is a parameter. A single interval counter is reloaded on entry to each state, and the sequencer moves on only when that counter reaches zero.

The host pulses `start` with an operation code, a start address and a word count. The block latches the address once and then works through the words. It relies on the device to advance its own address whenever the advance strobe is pulsed. The host supplies the write data for word `wordIdx` on `wrData`. For a read-back (dump), each sampled bus word is returned on `dumpWord` with a one-cycle `dumpValid`. If the verify flag is low at its sampling point, the block sets a sticky error flag and returns to idle at once. After reset the block stays busy for a wake-up interval so that the first latch strobe never comes too early.

Top module: `slave_prog_seq`

## Requirements
- R1: For WAKE_CYC (1100) cycles after reset release, `busy` is 1, all three strobes stay high, `errFlag` is 0, and `start` is ignored. The block then idles with `busy` 0 and all strobes high.
- R2: An accepted start drives `startAddr` on the bus. It pulls `latchN` low for LATCH_CYC (50) cycles and keeps the address driven for ADDR_HOLD_CYC (100) cycles from the latch fall. The first program pulse falls LATCH_TO_PULSE_CYC (220) cycles after `latchN` rises.
- R3: Op code 2'b00 (single program) gives one `pulseN` low of PGM_CYC (1500) cycles per word. The word's write data is driven on the bus for the whole pulse.
- R4: Op code 2'b01 (repeated program) gives REPEAT (3) pulses of PGM_CYC per word, separated by GAP_CYC (220) high cycles. The write data is driven through the pulses and the gaps.
- R5: Op code 2'b10 (dump) gives pulses of DUMP_CYC (50) cycles with the bus released. The bus is sampled on the last low cycle of each pulse and returned on `dumpWord`, with `dumpValid` high for exactly the next cycle.
- R6: After the last pulse of each word, all strobes stay high for POST_CYC (220) cycles. In the two program modes, `verifyIn` is sampled on the last of those cycles. In dump mode it is ignored.
- R7: When words remain, `advanceN` goes low for INC_CYC (240) cycles, then INC_GAP_CYC (170) high cycles pass before the next pulse. `wordIdx` increments as the advance strobe begins, and the bus is not driven while the advance strobe is low.
- R8: A low verify sample sets `errFlag` and returns the block to idle in the next cycle, skipping any remaining words. `errFlag` then holds until the next accepted start.
- R9: On normal or aborted completion, `done` is high for one cycle, which is the first idle cycle. An accepted start clears `errFlag`.
- R10: A start is ignored if it comes with op code 2'b11, with a word count of 0, or while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| opMode | input | 2 | 00 single program, 01 repeated program, 10 dump, 11 reserved |
| startAddr | input | BUS_W | First address, latched on acceptance |
| wordCount | input | CNT_W | Number of words to process |
| wrData | input | BUS_W | Write data for word `wordIdx` |
| busIn | input | BUS_W | Bus value read back from the device |
| verifyIn | input | 1 | Verify flag from the device, high means good |
| latchN | output | 1 | Address latch strobe, active low |
| pulseN | output | 1 | Program or dump pulse, active low |
| advanceN | output | 1 | Address advance strobe, active low |
| busOut | output | BUS_W | Value driven onto the shared bus |
| busDrive | output | 1 | Bus output enable |
| wordIdx | output | CNT_W | Index of the current word |
| dumpWord | output | BUS_W | Last word read back |
| dumpValid | output | 1 | One-cycle qualifier for `dumpWord` |
| busy | output | 1 | Operation or wake-up in progress |
| done | output | 1 | One-cycle completion marker |
| errFlag | output | 1 | Sticky verify failure |

## Verification
The bench works out when each strobe edge is due by summing interval lengths from the edge that accepts `start`. That edge is followed, with no extra register, by the latch fall, so each interval occupies exactly its parameter count of cycles. `dumpValid` and the data it qualifies come one cycle after the last pulse cycle. `done` and any new `errFlag` come one cycle after the last post-pulse cycle. The whole expected waveform is queued in advance, one entry per cycle, and that entry also supplies the verify and read-back inputs for the same cycle. Each entry is compared at the falling clock edge, half a period after the edge that produced it.

// File: rtl/slave_prog_pkg.sv
package slave_prog_pkg;

  typedef enum logic [1:0] {
    OP_SINGLE = 2'd0,
    OP_REPEAT = 2'd1,
    OP_DUMP   = 2'd2,
    OP_RSVD   = 2'd3
  } opMode_e;

  typedef enum logic [3:0] {
    ST_WAKE, ST_IDLE, ST_ALAT, ST_AHOLD, ST_AGAP,
    ST_PULSE, ST_PGAP, ST_POST, ST_INC, ST_IGAP
  } seqState_e;

  typedef enum logic [3:0] {
    IV_LATCH, IV_AHOLD, IV_AGAP, IV_DUMP, IV_PGM,
    IV_GAP, IV_POST, IV_INC, IV_IGAP
  } ivSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   accept;
    logic   load;
    ivSel_e sel;
    logic   repLoad;
    logic   repMulti;
    logic   repDec;
    logic   nextWord;
    logic   capture;
    logic   driveAddr;
    logic   driveData;
  } seqCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic ivZero;
    logic lastWord;
    logic lastRep;
  } seqStat_t;

endpackage

// File: rtl/slave_prog_dp.sv
module slave_prog_dp
  import slave_prog_pkg::*;
#(
  parameter int BUS_W              = 16,
  parameter int CNT_W              = 16,
  parameter int WAKE_CYC           = 1100,
  parameter int LATCH_CYC          = 50,
  parameter int ADDR_HOLD_CYC      = 100,
  parameter int LATCH_TO_PULSE_CYC = 220,
  parameter int DUMP_CYC           = 50,
  parameter int PGM_CYC            = 1500,
  parameter int GAP_CYC            = 220,
  parameter int POST_CYC           = 220,
  parameter int INC_CYC            = 240,
  parameter int INC_GAP_CYC        = 170,
  parameter int REPEAT             = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqCmd_t          cmd,
  output seqStat_t         stat,
  input  logic [BUS_W-1:0] startAddr,
  input  logic [CNT_W-1:0] wordCount,
  input  logic [BUS_W-1:0] wrData,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic [CNT_W-1:0] wordIdx,
  output logic [BUS_W-1:0] dumpWord,
  output logic             dumpValid
);

  localparam int AHOLD_LEN = ADDR_HOLD_CYC - LATCH_CYC;
  localparam int AGAP_LEN  = LATCH_TO_PULSE_CYC - AHOLD_LEN;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int IV_MAX = maxOf(maxOf(maxOf(WAKE_CYC, PGM_CYC), maxOf(INC_CYC, POST_CYC)),
                                maxOf(maxOf(GAP_CYC, AGAP_LEN), maxOf(DUMP_CYC, INC_GAP_CYC)));
  localparam int IV_W  = $clog2(IV_MAX + 1);
  localparam int REP_W = $clog2(REPEAT + 1);

  logic [IV_W-1:0]  ivCnt;
  logic [BUS_W-1:0] addrReg;
  logic [CNT_W-1:0] wordsLeft;
  logic [CNT_W-1:0] idxReg;
  logic [REP_W-1:0] repLeft;
  logic [BUS_W-1:0] dumpReg;
  logic             dumpVld;
  logic [IV_W-1:0]  loadVal;

  // length of the interval selected by the control, minus one
  always_comb begin
    int len;
    case (cmd.sel)
      IV_LATCH: len = LATCH_CYC;
      IV_AHOLD: len = AHOLD_LEN;
      IV_AGAP:  len = AGAP_LEN;
      IV_DUMP:  len = DUMP_CYC;
      IV_PGM:   len = PGM_CYC;
      IV_GAP:   len = GAP_CYC;
      IV_POST:  len = POST_CYC;
      IV_INC:   len = INC_CYC;
      IV_IGAP:  len = INC_GAP_CYC;
      default:  len = 1;
    endcase
    loadVal = IV_W'(len - 1);
  end

  // single shared interval counter; its reset value times the wake-up (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ivCnt <= IV_W'(WAKE_CYC - 1);
    else if (cmd.load)       ivCnt <= loadVal;
    else if (ivCnt != '0)    ivCnt <= ivCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg   <= '0;
      wordsLeft <= '0;
      idxReg    <= '0;
      repLeft   <= '0;
      dumpReg   <= '0;
      dumpVld   <= 1'b0;
    end else begin
      if (cmd.accept) begin
        addrReg   <= startAddr;
        wordsLeft <= wordCount;
        idxReg    <= '0;
      end else if (cmd.nextWord) begin
        wordsLeft <= wordsLeft - 1'b1;
        idxReg    <= idxReg + 1'b1;
      end
      if (cmd.repLoad)     repLeft <= cmd.repMulti ? REP_W'(REPEAT) : REP_W'(1);
      else if (cmd.repDec) repLeft <= repLeft - 1'b1;
      if (cmd.capture) dumpReg <= busIn;
      dumpVld <= cmd.capture;
    end
  end

  assign stat.ivZero   = (ivCnt == '0);
  assign stat.lastWord = (wordsLeft == CNT_W'(1));
  assign stat.lastRep  = (repLeft == REP_W'(1));

  assign busOut    = cmd.driveAddr ? addrReg : (cmd.driveData ? wrData : '0);
  assign wordIdx   = idxReg;
  assign dumpWord  = dumpReg;
  assign dumpValid = dumpVld;

endmodule

// File: rtl/slave_prog_ctrl.sv
module slave_prog_ctrl
  import slave_prog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       opMode,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             verifyIn,
  input  seqStat_t         stat,
  output seqCmd_t          cmd,
  output logic             latchN,
  output logic             pulseN,
  output logic             advanceN,
  output logic             busDrive,
  output logic             busy,
  output logic             done,
  output logic             errFlag
);

  seqState_e state, nextState;
  opMode_e   modeReg;
  logic      doneReg, errReg;
  logic      doneSet, errSet, startOk;
  ivSel_e    pulseSel;

  // R10: reserved op code or empty count never starts
  assign startOk = start && (opMode != 2'b11) && (wordCount != '0);

  always_comb begin
    nextState     = state;
    cmd           = '0;
    cmd.sel       = IV_LATCH;
    doneSet       = 1'b0;
    errSet        = 1'b0;
    pulseSel      = (modeReg == OP_DUMP) ? IV_DUMP : IV_PGM;
    cmd.repMulti  = (modeReg == OP_REPEAT);
    cmd.driveAddr = (state == ST_ALAT) || (state == ST_AHOLD);
    cmd.driveData = ((state == ST_PULSE) || (state == ST_PGAP)) && (modeReg != OP_DUMP);
    case (state)
      ST_WAKE:  if (stat.ivZero) nextState = ST_IDLE;
      ST_IDLE:  if (startOk) begin
                  cmd.accept = 1'b1; cmd.load = 1'b1; cmd.sel = IV_LATCH;
                  nextState = ST_ALAT;
                end
      ST_ALAT:  if (stat.ivZero) begin
                  cmd.load = 1'b1; cmd.sel = IV_AHOLD; nextState = ST_AHOLD;
                end
      ST_AHOLD: if (stat.ivZero) begin
                  cmd.load = 1'b1; cmd.sel = IV_AGAP; nextState = ST_AGAP;
                end
      ST_AGAP, ST_IGAP:
                if (stat.ivZero) begin
                  cmd.load = 1'b1; cmd.sel = pulseSel; cmd.repLoad = 1'b1;
                  nextState = ST_PULSE;
                end
      ST_PULSE: if (stat.ivZero) begin
                  cmd.capture = (modeReg == OP_DUMP);
                  cmd.load    = 1'b1;
                  if (stat.lastRep) begin
                    cmd.sel = IV_POST; nextState = ST_POST;
                  end else begin
                    cmd.sel = IV_GAP; cmd.repDec = 1'b1; nextState = ST_PGAP;
                  end
                end
      ST_PGAP:  if (stat.ivZero) begin
                  cmd.load = 1'b1; cmd.sel = pulseSel; nextState = ST_PULSE;
                end
      ST_POST:  if (stat.ivZero) begin
                  if ((modeReg != OP_DUMP) && !verifyIn) begin
                    errSet = 1'b1; doneSet = 1'b1; nextState = ST_IDLE;
                  end else if (stat.lastWord) begin
                    doneSet = 1'b1; nextState = ST_IDLE;
                  end else begin
                    cmd.load = 1'b1; cmd.sel = IV_INC; cmd.nextWord = 1'b1;
                    nextState = ST_INC;
                  end
                end
      ST_INC:   if (stat.ivZero) begin
                  cmd.load = 1'b1; cmd.sel = IV_IGAP; nextState = ST_IGAP;
                end
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAKE;
      modeReg <= OP_SINGLE;
      doneReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      state   <= nextState;
      doneReg <= doneSet;
      if (cmd.accept) begin
        modeReg <= opMode_e'(opMode);
        errReg  <= 1'b0;
      end else if (errSet) begin
        errReg  <= 1'b1;
      end
    end
  end

  assign latchN   = (state != ST_ALAT);
  assign pulseN   = (state != ST_PULSE);
  assign advanceN = (state != ST_INC);
  assign busDrive = cmd.driveAddr || cmd.driveData;
  assign busy     = (state != ST_IDLE);
  assign done     = doneReg;
  assign errFlag  = errReg;

endmodule

// File: rtl/slave_prog_seq.sv
module slave_prog_seq
  import slave_prog_pkg::*;
#(
  parameter int BUS_W              = 16,
  parameter int CNT_W              = 16,
  parameter int WAKE_CYC           = 1100,
  parameter int LATCH_CYC          = 50,
  parameter int ADDR_HOLD_CYC      = 100,
  parameter int LATCH_TO_PULSE_CYC = 220,
  parameter int DUMP_CYC           = 50,
  parameter int PGM_CYC            = 1500,
  parameter int GAP_CYC            = 220,
  parameter int POST_CYC           = 220,
  parameter int INC_CYC            = 240,
  parameter int INC_GAP_CYC        = 170,
  parameter int REPEAT             = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       opMode,
  input  logic [BUS_W-1:0] startAddr,
  input  logic [CNT_W-1:0] wordCount,
  input  logic [BUS_W-1:0] wrData,
  input  logic [BUS_W-1:0] busIn,
  input  logic             verifyIn,
  output logic             latchN,
  output logic             pulseN,
  output logic             advanceN,
  output logic [BUS_W-1:0] busOut,
  output logic             busDrive,
  output logic [CNT_W-1:0] wordIdx,
  output logic [BUS_W-1:0] dumpWord,
  output logic             dumpValid,
  output logic             busy,
  output logic             done,
  output logic             errFlag
);

  seqCmd_t  cmd;
  seqStat_t stat;

  slave_prog_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opMode(opMode),
    .wordCount(wordCount), .verifyIn(verifyIn), .stat(stat), .cmd(cmd),
    .latchN(latchN), .pulseN(pulseN), .advanceN(advanceN),
    .busDrive(busDrive), .busy(busy), .done(done), .errFlag(errFlag)
  );

  slave_prog_dp #(
    .BUS_W(BUS_W), .CNT_W(CNT_W), .WAKE_CYC(WAKE_CYC), .LATCH_CYC(LATCH_CYC),
    .ADDR_HOLD_CYC(ADDR_HOLD_CYC), .LATCH_TO_PULSE_CYC(LATCH_TO_PULSE_CYC),
    .DUMP_CYC(DUMP_CYC), .PGM_CYC(PGM_CYC), .GAP_CYC(GAP_CYC), .POST_CYC(POST_CYC),
    .INC_CYC(INC_CYC), .INC_GAP_CYC(INC_GAP_CYC), .REPEAT(REPEAT)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .stat(stat), .startAddr(startAddr),
    .wordCount(wordCount), .wrData(wrData), .busIn(busIn), .busOut(busOut),
    .wordIdx(wordIdx), .dumpWord(dumpWord), .dumpValid(dumpValid)
  );

endmodule

// File: rtl/slave_prog_chk.sv
module slave_prog_chk #(
  parameter int LATCH_CYC = 50,
  parameter int DUMP_CYC  = 50,
  parameter int INC_CYC   = 240
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] opMode,
  input logic       latchN,
  input logic       pulseN,
  input logic       advanceN,
  input logic       busDrive,
  input logic       busy,
  input logic       done,
  input logic       errFlag,
  input logic       dumpValid
);

  int latchRun, pulseRun, incRun;

  // run-length counters for each strobe's low phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchRun <= 0; pulseRun <= 0; incRun <= 0;
    end else begin
      latchRun <= latchN   ? 0 : latchRun + 1;
      pulseRun <= pulseN   ? 0 : pulseRun + 1;
      incRun   <= advanceN ? 0 : incRun + 1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (latchN && pulseN && advanceN && !busDrive));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!latchN, !pulseN, !advanceN}));

  p_latch_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latchN) |-> (latchRun == LATCH_CYC));

  p_pulse_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulseN) |-> (pulseRun >= DUMP_CYC));

  p_dump_after_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dumpValid |-> (pulseN && $past(!pulseN)));

  p_inc_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(advanceN) |-> (incRun == INC_CYC));

  p_inc_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !advanceN |-> !busDrive);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !start) |=> errFlag);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_rsvd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (opMode == 2'b11)) |=> !busy);

endmodule

bind slave_prog_seq slave_prog_chk #(
  .LATCH_CYC(LATCH_CYC), .DUMP_CYC(DUMP_CYC), .INC_CYC(INC_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .opMode(opMode), .latchN(latchN),
  .pulseN(pulseN), .advanceN(advanceN), .busDrive(busDrive), .busy(busy),
  .done(done), .errFlag(errFlag), .dumpValid(dumpValid)
);

// File: tb/slave_prog_seq_tb_top.sv
module slave_prog_seq_tb_top;

  localparam int WAKE_CYC = 1100, LATCH_CYC = 50, ADDR_HOLD_CYC = 100;
  localparam int LATCH_TO_PULSE_CYC = 220, DUMP_CYC = 50, PGM_CYC = 1500;
  localparam int GAP_CYC = 220, POST_CYC = 220, INC_CYC = 240, INC_GAP_CYC = 170;
  localparam int REPEAT = 3;

  typedef struct packed {
    logic [3:0]  req;
    logic        latchN, pulseN, incN, busy, done, err, drive;
    logic [15:0] bus;
    logic        vin;
    logic [15:0] din;
    logic        dvalid;
    logic [15:0] dword;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opMode = 2'd0;
  logic [15:0] startAddr = '0;
  logic [15:0] wordCount = '0;
  logic [15:0] wrData;
  logic [15:0] busIn = '0;
  logic        verifyIn = 1'b1;
  logic        latchN, pulseN, advanceN, busDrive, dumpValid, busy, done, errFlag;
  logic [15:0] busOut, wordIdx, dumpWord;

  logic [15:0] pgmWords [4];
  logic [15:0] dumpSrc  [4];
  exp_t        q [$];
  logic        modelErr = 1'b0;
  logic        cmpOn = 1'b0;
  int          nChecks = 0;
  int          nFail = 0;

  always #2 clk = ~clk;

  assign wrData = pgmWords[wordIdx[1:0]];

  slave_prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opMode(opMode), .startAddr(startAddr),
    .wordCount(wordCount), .wrData(wrData), .busIn(busIn), .verifyIn(verifyIn),
    .latchN(latchN), .pulseN(pulseN), .advanceN(advanceN), .busOut(busOut),
    .busDrive(busDrive), .wordIdx(wordIdx), .dumpWord(dumpWord), .dumpValid(dumpValid),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  function automatic exp_t idleE(logic er, logic [3:0] r);
    exp_t e;
    e = '0; e.req = r; e.latchN = 1'b1; e.pulseN = 1'b1; e.incN = 1'b1;
    e.err = er; e.vin = 1'b1;
    return e;
  endfunction

  task automatic pushN(int n, exp_t e);
    repeat (n) q.push_back(e);
  endtask

  task automatic cmpF(string nm, logic [3:0] r, logic [15:0] a, logic [15:0] x);
    nChecks++;
    if (a !== x) begin
      nFail++;
      $display("FAIL R%0d %s actual=%h expected=%h at %0t", r, nm, a, x, $time);
    end
  endtask

  // per-cycle reference comparison, half a period after the producing edge
  always @(negedge clk) begin
    exp_t e;
    if (cmpOn) begin
      if (q.size() > 0) e = q.pop_front();
      else              e = idleE(modelErr, 4'd9);
      verifyIn = e.vin;
      busIn    = e.din;
      cmpF("latchN",    e.req, {15'd0, latchN},    {15'd0, e.latchN});
      cmpF("pulseN",    e.req, {15'd0, pulseN},    {15'd0, e.pulseN});
      cmpF("advanceN",  e.req, {15'd0, advanceN},  {15'd0, e.incN});
      cmpF("busy",      e.req, {15'd0, busy},      {15'd0, e.busy});
      cmpF("done",      e.req, {15'd0, done},      {15'd0, e.done});
      cmpF("errFlag",   e.req, {15'd0, errFlag},   {15'd0, e.err});
      cmpF("busDrive",  e.req, {15'd0, busDrive},  {15'd0, e.drive});
      cmpF("dumpValid", e.req, {15'd0, dumpValid}, {15'd0, e.dvalid});
      if (e.drive)  cmpF("busOut",   e.req, busOut,   e.bus);
      if (e.dvalid) cmpF("dumpWord", e.req, dumpWord, e.dword);
    end
  end

  // Behavioural expected waveform for one accepted operation
  task automatic genOp(logic [1:0] m, logic [15:0] a, int n, int failIdx);
    exp_t b, e;
    int   reps, width;
    logic failed;
    failed = 1'b0;
    q.push_back(idleE(modelErr, 4'd10));          // cycle before the accepting edge
    b = idleE(1'b0, 4'd2); b.busy = 1'b1;         // R9: accept clears the error
    e = b; e.latchN = 1'b0; e.drive = 1'b1; e.bus = a;
    pushN(LATCH_CYC, e);                          // R2 latch low
    e.latchN = 1'b1;
    pushN(ADDR_HOLD_CYC - LATCH_CYC, e);          // R2 address hold
    e = b;
    pushN(LATCH_TO_PULSE_CYC - (ADDR_HOLD_CYC - LATCH_CYC), e);
    reps  = (m == 2'd1) ? REPEAT : 1;
    width = (m == 2'd2) ? DUMP_CYC : PGM_CYC;
    for (int w = 0; w < n; w++) begin
      for (int p = 0; p < reps; p++) begin
        e = b;
        if (m == 2'd2)      e.req = 4'd5;         // R5 dump pulse
        else if (m == 2'd1) e.req = 4'd4;         // R4 repeated pulses
        else                e.req = 4'd3;         // R3 single pulse
        e.pulseN = 1'b0; e.drive = (m != 2'd2); e.bus = pgmWords[w]; e.din = dumpSrc[w];
        pushN(width, e);
        if (p < reps - 1) begin
          e.pulseN = 1'b1; e.din = '0;
          pushN(GAP_CYC, e);
        end
      end
      e = b; e.req = 4'd6;                        // R6 post-pulse wait and verify
      e.vin = (w != failIdx);
      e.dvalid = (m == 2'd2); e.dword = dumpSrc[w];
      q.push_back(e);
      e.dvalid = 1'b0;
      pushN(POST_CYC - 1, e);
      if (m != 2'd2 && w == failIdx) begin
        failed = 1'b1;                            // R8 abort path
        break;
      end
      if (w == n - 1) break;
      e = b; e.req = 4'd7; e.incN = 1'b0;         // R7 advance strobe
      pushN(INC_CYC, e);
      e.incN = 1'b1;
      pushN(INC_GAP_CYC, e);
    end
    e = idleE(failed, failed ? 4'd8 : 4'd9);
    e.done = 1'b1;
    q.push_back(e);
    modelErr = failed;
  endtask

  task automatic waitDrain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic launch(logic [1:0] m, logic [15:0] a, int n, int failIdx, bit midStart);
    waitDrain();
    @(posedge clk); #1;
    start = 1'b1; opMode = m; startAddr = a; wordCount = 16'(n);
    genOp(m, a, n, failIdx);
    @(posedge clk); #1;
    start = 1'b0;
    if (midStart) begin                           // R10 start while busy
      repeat (300) @(posedge clk);
      #1 start = 1'b1; opMode = 2'd0; wordCount = 16'd2;
      @(posedge clk); #1 start = 1'b0;
    end
  endtask

  task automatic badStart(logic [1:0] m, logic [15:0] n);
    waitDrain();
    @(posedge clk); #1;
    start = 1'b1; opMode = m; wordCount = n;
    pushN(21, idleE(modelErr, 4'd10));            // R10 nothing happens, err kept
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    pgmWords[0] = 16'hA5C3; pgmWords[1] = 16'h0F1E;
    pgmWords[2] = 16'h7B20; pgmWords[3] = 16'hFFFE;
    dumpSrc[0]  = 16'h1234; dumpSrc[1]  = 16'hBEEF;
    dumpSrc[2]  = 16'h0001; dumpSrc[3]  = 16'h8000;
    repeat (4) @(posedge clk);
    @(negedge clk);                               // R1 reset state
    cmpF("reset latchN",   4'd1, {15'd0, latchN},   16'd1);
    cmpF("reset pulseN",   4'd1, {15'd0, pulseN},   16'd1);
    cmpF("reset advanceN", 4'd1, {15'd0, advanceN}, 16'd1);
    cmpF("reset errFlag",  4'd1, {15'd0, errFlag},  16'd0);
    cmpF("reset busy",     4'd1, {15'd0, busy},     16'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    begin
      exp_t w;
      w = idleE(1'b0, 4'd1); w.busy = 1'b1;
      pushN(WAKE_CYC, w);                         // R1 wake interval
    end
    cmpOn = 1'b1;
    repeat (10) @(posedge clk);
    #1 start = 1'b1; opMode = 2'd0; wordCount = 16'd3;   // R1 start during wake
    repeat (3) @(posedge clk);
    #1 start = 1'b0;

    launch(2'd0, 16'h2000, 3, -1, 1'b0);          // R3 single program, R7 advance
    launch(2'd1, 16'h4100, 2, -1, 1'b1);          // R4 repeated, R10 mid-op start
    launch(2'd2, 16'h5FF0, 4, -1, 1'b0);          // R5 dump
    launch(2'd0, 16'h2222, 3, 1, 1'b0);           // R8 verify failure on word 1
    badStart(2'd3, 16'd2);                        // R10 reserved op code
    badStart(2'd0, 16'd0);                        // R10 zero count
    launch(2'd2, 16'h3000, 1, 0, 1'b0);           // R9 err cleared, R6 verify ignored in dump
    waitDrain();
    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule